// File: doc/BRIEF.md
# Boolean Expression Truth-Table Engine

This engine accepts a Boolean expression in infix form over four variables, one byte per clock on a valid/ready stream, and returns the 16-bit truth table of that expression. A marker on the final byte closes the expression. The engine works in two phases. A converter first turns the infix text into postfix tokens, using an operator stack and a priority comparison, and writes them into a small token buffer that is closed by an end token. An evaluator then walks that buffer sixteen times, once for each assignment of the variables, on a one-bit operand stack. Each walk fills one bit of the table.

Variables are written `I0` to `I3`. The letter `I` is dropped and the digit picks the variable. The operators are OR `+`, AND `*`, XOR `@` and prefix NOT `~`, and parentheses group terms. A space is ignored. Operators still on the stack when the expression ends count as an error, so any expression that contains an operator must be wrapped in an outer pair of parentheses. The table is ready when `done` pulses. Two flags report syntax faults and capacity faults.

The top-level controller has three states. `TP_LOAD` feeds characters to the converter and moves on when the conversion finishes: to `TP_EVAL` if the conversion was clean, or straight to `TP_DONE` on an error. `TP_EVAL` moves to `TP_DONE` when the sixteenth pass ends. `TP_DONE` lasts one cycle and returns to `TP_LOAD`. The converter's states are:
- `CV_SCAN` takes one character per cycle.
- `CV_OPPOP` pops operators that have an equal or higher rank before it pushes the incoming one.
- `CV_PARPOP` pops operators down to the matching `(`.
- `CV_FINAL` appends the end token and reports the result.

`CV_SCAN` moves to `CV_OPPOP` or `CV_PARPOP` when a pop is needed, and to `CV_FINAL` on the last character. The pop states return to `CV_SCAN`, or go to `CV_FINAL` if the character that caused them was the last one. The evaluator moves from `EV_IDLE` to `EV_STEP` on start, and from `EV_STEP` to `EV_FIN` after pass 15. `EV_FIN` returns to `EV_IDLE`.

Top module: `bexpr_tt_engine`

## Requirements
- R1: After reset, in_ready is 1, and done, table_out, err_syntax and err_capacity are all 0.
- R2: The character codes '0' to '3' name variables 0 to 3, and 'I' and space have no effect. On pass i, variable k takes bit k of i, and the expression's value on that pass becomes bit i of table_out. For example, a lone I2 gives 16'hF0F0.
- R3: OR ranks below AND and XOR, and AND and XOR share one rank. An incoming operator first pops every stacked operator of equal or higher rank, so operators of equal rank group left to right.
- R4: Prefix NOT ranks above every binary operator and inverts only the operand that follows it.
- R5: A ')' pops operators to the output down to the nearest '(' and then discards that '('. A ')' that finds no '(' sets err_syntax.
- R6: Any character other than '0'-'3', 'I', space, '(', ')', '+', '*', '@' or '~' sets err_syntax.
- R7: An operator or '(' still on the operator stack at the end of the expression sets err_syntax.
- R8: err_capacity is set when the operator stack would exceed 16 entries, when the postfix buffer would exceed 64 tokens (the end token included), or when an evaluation pass has too few or too many operands.
- R9: When an expression ends with either flag set, table_out is 0 at done. The flags keep their value after done and clear when the first character of the next expression is accepted.
- R10: in_last on a character ends the expression. in_ready is low from then until done, and done is high for exactly one cycle.
- R11: in_ready is low while the converter pops operators, and no character offered during that time is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A character is offered |
| in_char | input | 8 | Character code of the expression |
| in_last | input | 1 | Marks the final character of an expression |
| in_ready | output | 1 | The engine takes the offered character this cycle |
| table_out | output | 16 | Truth table; bit i is the value on pass i |
| done | output | 1 | One-cycle pulse when table_out and the flags are final |
| err_syntax | output | 1 | Malformed expression |
| err_capacity | output | 1 | Stack or buffer overflow or underflow |

## Verification
Two functions can fall in the same cycle: the end-of-expression handling and the operator popping. This happens when in_last arrives on a ')' or on an operator that must drain the stack. The end-stack check must then wait until the pops are complete. The bench provokes this because every parenthesised case ends on such a ')', and it also runs a postfix buffer filled to exactly 64 tokens, where the end token takes the last slot. Correct results are judged by the table and the flags matching values that the bench computes from variable masks, and by both flags staying clear at those boundaries.

// File: rtl/bexpr_pkg.sv
package bexpr_pkg;

    // Postfix token codes; the low two bits of a variable token pick the variable.
    typedef enum logic [3:0] {
        TK_V0  = 4'd0,
        TK_V1  = 4'd1,
        TK_V2  = 4'd2,
        TK_V3  = 4'd3,
        TK_OR  = 4'd4,
        TK_AND = 4'd5,
        TK_XOR = 4'd6,
        TK_NOT = 4'd7,
        TK_END = 4'd8
    } tok_t;

    // Operator stack entries.
    typedef enum logic [2:0] {
        OP_LPAR = 3'd0,
        OP_OR   = 3'd1,
        OP_AND  = 3'd2,
        OP_XOR  = 3'd3,
        OP_NOT  = 3'd4
    } op_t;

    // Character classes.
    typedef enum logic [2:0] {
        CH_SKIP,
        CH_VAR,
        CH_LPAR,
        CH_RPAR,
        CH_OP,
        CH_BAD
    } chcls_t;

    // Binding rank: '(' lowest, then OR, then AND/XOR, then NOT.
    function automatic logic [1:0] op_rank(input op_t o);
        case (o)
            OP_LPAR:        op_rank = 2'd0;
            OP_OR:          op_rank = 2'd1;
            OP_AND, OP_XOR: op_rank = 2'd2;
            default:        op_rank = 2'd3;
        endcase
    endfunction

    function automatic tok_t op_tok(input op_t o);
        case (o)
            OP_OR:   op_tok = TK_OR;
            OP_AND:  op_tok = TK_AND;
            OP_XOR:  op_tok = TK_XOR;
            default: op_tok = TK_NOT;
        endcase
    endfunction

endpackage

// File: rtl/bexpr_pbuf.sv
module bexpr_pbuf
    import bexpr_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  tok_t                     wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output tok_t                     rdata
);
    tok_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/bexpr_convert.sv
module bexpr_convert
    import bexpr_pkg::*;
#(
    parameter int PF_DEPTH = 64,
    parameter int OS_DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic                        in_valid,
    input  logic [7:0]                  in_char,
    input  logic                        in_last,
    output logic                        in_ready,
    output logic                        wr_en,
    output logic [$clog2(PF_DEPTH)-1:0] wr_addr,
    output tok_t                        wr_tok,
    output logic                        fin,
    output logic                        fin_syn,
    output logic                        fin_cap
);
    localparam int PAW = $clog2(PF_DEPTH);
    localparam int PCW = PAW + 1;
    localparam int OSW = $clog2(OS_DEPTH);
    localparam int OCW = OSW + 1;

    typedef enum logic [1:0] {CV_SCAN, CV_OPPOP, CV_PARPOP, CV_FINAL} cv_state_t;

    cv_state_t state, nxt;
    op_t       opstk [OS_DEPTH];
    logic [OCW-1:0] sp;
    logic [PCW-1:0] wp;
    op_t       pend;
    logic      pend_last;
    logic      syn_r, cap_r;

    op_t       top_op, cop, push_op;
    chcls_t    cls;
    logic      accept, wr_req, push, pop, set_syn, ld_pend;
    logic      sp_full, wp_full;

    assign accept  = in_valid && in_ready;
    assign sp_full = (sp == OCW'(OS_DEPTH));
    assign wp_full = (wp == PCW'(PF_DEPTH));
    assign top_op  = (sp != '0) ? opstk[OSW'(sp - OCW'(1))] : OP_LPAR;

    // Character classification
    always_comb begin
        cop = OP_OR;
        case (in_char)
            8'h20, 8'h49:                cls = CH_SKIP;
            8'h30, 8'h31, 8'h32, 8'h33:  cls = CH_VAR;
            8'h28:                       cls = CH_LPAR;
            8'h29:                       cls = CH_RPAR;
            8'h2B: begin cls = CH_OP; cop = OP_OR;  end
            8'h2A: begin cls = CH_OP; cop = OP_AND; end
            8'h40: begin cls = CH_OP; cop = OP_XOR; end
            8'h7E: begin cls = CH_OP; cop = OP_NOT; end
            default:                     cls = CH_BAD;
        endcase
    end

    // Next state and datapath commands
    always_comb begin
        nxt     = state;
        wr_req  = 1'b0;
        wr_tok  = TK_END;
        push    = 1'b0;
        push_op = cop;
        pop     = 1'b0;
        set_syn = 1'b0;
        ld_pend = 1'b0;
        unique case (state)
            CV_SCAN: begin
                if (accept) begin
                    unique case (cls)
                        CH_VAR: begin
                            wr_req = 1'b1;
                            wr_tok = tok_t'({2'b00, in_char[1:0]});
                        end
                        CH_LPAR: begin
                            push    = 1'b1;
                            push_op = OP_LPAR;
                        end
                        CH_OP: begin
                            if (sp != '0 && op_rank(cop) <= op_rank(top_op)) begin
                                ld_pend = 1'b1;
                                nxt     = CV_OPPOP;
                            end else begin
                                push = 1'b1;
                            end
                        end
                        CH_RPAR: begin
                            if (sp == '0) begin
                                set_syn = 1'b1;
                            end else begin
                                ld_pend = 1'b1;
                                nxt     = CV_PARPOP;
                            end
                        end
                        CH_BAD:  set_syn = 1'b1;
                        CH_SKIP: ;
                    endcase
                    if (in_last && nxt == CV_SCAN) begin
                        nxt = CV_FINAL;
                    end
                end
            end
            CV_OPPOP: begin
                if (sp != '0 && op_rank(pend) <= op_rank(top_op)) begin
                    wr_req = 1'b1;
                    wr_tok = op_tok(top_op);
                    pop    = 1'b1;
                end else begin
                    push    = 1'b1;
                    push_op = pend;
                    nxt     = pend_last ? CV_FINAL : CV_SCAN;
                end
            end
            CV_PARPOP: begin
                if (sp == '0) begin
                    set_syn = 1'b1;
                    nxt     = pend_last ? CV_FINAL : CV_SCAN;
                end else if (top_op == OP_LPAR) begin
                    pop = 1'b1;
                    nxt = pend_last ? CV_FINAL : CV_SCAN;
                end else begin
                    wr_req = 1'b1;
                    wr_tok = op_tok(top_op);
                    pop    = 1'b1;
                end
            end
            CV_FINAL: begin
                wr_req = 1'b1;
                wr_tok = TK_END;
                nxt    = CV_SCAN;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CV_SCAN;
        else        state <= nxt;
    end

    // Stack, pointers and per-expression flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp        <= '0;
            wp        <= '0;
            pend      <= OP_OR;
            pend_last <= 1'b0;
            syn_r     <= 1'b0;
            cap_r     <= 1'b0;
        end else if (state == CV_FINAL) begin
            sp    <= '0;
            wp    <= '0;
            syn_r <= 1'b0;
            cap_r <= 1'b0;
        end else begin
            if (ld_pend) begin
                pend      <= cop;
                pend_last <= in_last;
            end
            if (set_syn) syn_r <= 1'b1;
            if (wr_req) begin
                if (wp_full) cap_r <= 1'b1;
                else         wp    <= wp + PCW'(1);
            end
            if (push) begin
                if (sp_full) cap_r <= 1'b1;
                else         sp    <= sp + OCW'(1);
            end else if (pop) begin
                sp <= sp - OCW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push && !sp_full) begin
            opstk[sp[OSW-1:0]] <= push_op;
        end
    end

    // Outputs
    assign in_ready = en && (state == CV_SCAN);
    assign wr_en    = wr_req && !wp_full;
    assign wr_addr  = wp[PAW-1:0];
    assign fin      = (state == CV_FINAL);
    assign fin_syn  = syn_r || (sp != '0);
    assign fin_cap  = cap_r || wp_full;

    // R8
    sp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= OCW'(OS_DEPTH));
    // R8
    wp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp <= PCW'(PF_DEPTH));
    // R5
    rpar_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cls == CH_RPAR && sp == '0) |=> syn_r);
    // R3
    oppop_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CV_OPPOP && sp != '0 && op_rank(pend) <= op_rank(top_op))
        |=> (sp == $past(sp) - OCW'(1)));

endmodule

// File: rtl/bexpr_eval.sv
module bexpr_eval
    import bexpr_pkg::*;
#(
    parameter int PF_DEPTH = 64,
    parameter int ES_DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    output logic [$clog2(PF_DEPTH)-1:0] rd_addr,
    input  tok_t                        rd_tok,
    output logic                        fin,
    output logic [15:0]                 tbl,
    output logic                        err
);
    localparam int PAW = $clog2(PF_DEPTH);
    localparam int ESW = $clog2(ES_DEPTH);
    localparam int ECW = ESW + 1;

    typedef enum logic [1:0] {EV_IDLE, EV_STEP, EV_FIN} ev_state_t;

    ev_state_t state, nxt;
    logic [3:0]     pass;
    logic [PAW-1:0] rp;
    logic [ECW-1:0] depth;
    logic [ES_DEPTH-1:0] st;
    logic           err_r;
    logic [ESW-1:0] top_i, sec_i;
    logic           rp_end, tok_bin, bin_res;

    assign top_i   = ESW'(depth - ECW'(1));
    assign sec_i   = ESW'(depth - ECW'(2));
    assign rp_end  = (rp == PAW'(PF_DEPTH - 1));
    assign tok_bin = (rd_tok == TK_OR) || (rd_tok == TK_AND) || (rd_tok == TK_XOR);

    always_comb begin
        case (rd_tok)
            TK_OR:   bin_res = st[sec_i] | st[top_i];
            TK_AND:  bin_res = st[sec_i] & st[top_i];
            default: bin_res = st[sec_i] ^ st[top_i];
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            EV_IDLE: if (start) nxt = EV_STEP;
            EV_STEP: begin
                if (rd_tok == TK_END) begin
                    if (pass == 4'hF) nxt = EV_FIN;
                end else if (rp_end) begin
                    nxt = EV_FIN;
                end
            end
            EV_FIN:  nxt = EV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= EV_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass  <= '0;
            rp    <= '0;
            depth <= '0;
            st    <= '0;
            tbl   <= '0;
            err_r <= 1'b0;
        end else if (state == EV_IDLE) begin
            if (start) begin
                pass  <= '0;
                rp    <= '0;
                depth <= '0;
                err_r <= 1'b0;
            end
        end else if (state == EV_STEP) begin
            if (rd_tok == TK_END) begin
                tbl[pass] <= (depth != '0) && st[top_i];
                if (depth == '0) err_r <= 1'b1;
                depth <= '0;
                rp    <= '0;
                pass  <= pass + 4'd1;
            end else begin
                rp <= rp + PAW'(1);
                if (rp_end) err_r <= 1'b1;
                if (rd_tok == TK_V0 || rd_tok == TK_V1 || rd_tok == TK_V2 || rd_tok == TK_V3) begin
                    if (depth == ECW'(ES_DEPTH)) begin
                        err_r <= 1'b1;
                    end else begin
                        st[depth[ESW-1:0]] <= pass[rd_tok[1:0]];
                        depth <= depth + ECW'(1);
                    end
                end else if (rd_tok == TK_NOT) begin
                    if (depth == '0) err_r <= 1'b1;
                    else             st[top_i] <= ~st[top_i];
                end else if (tok_bin) begin
                    if (depth < ECW'(2)) begin
                        err_r <= 1'b1;
                    end else begin
                        st[sec_i] <= bin_res;
                        depth     <= depth - ECW'(1);
                    end
                end else begin
                    err_r <= 1'b1;
                end
            end
        end
    end

    assign rd_addr = rp;
    assign fin     = (state == EV_FIN);
    assign err     = err_r;

    // R8
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= ECW'(ES_DEPTH));
    // R2
    pass_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EV_STEP && rd_tok == TK_END && pass != 4'hF)
        |=> (pass == $past(pass) + 4'd1));

endmodule

// File: rtl/bexpr_tt_engine.sv
module bexpr_tt_engine
    import bexpr_pkg::*;
#(
    parameter int PF_DEPTH = 64,
    parameter int OS_DEPTH = 16,
    parameter int ES_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_char,
    input  logic        in_last,
    output logic        in_ready,
    output logic [15:0] table_out,
    output logic        done,
    output logic        err_syntax,
    output logic        err_capacity
);
    localparam int PAW = $clog2(PF_DEPTH);

    typedef enum logic [1:0] {TP_LOAD, TP_EVAL, TP_DONE} tp_state_t;

    tp_state_t state, nxt;

    logic           cv_en, cv_fin, cv_syn, cv_cap;
    logic           wr_en;
    logic [PAW-1:0] wr_addr, rd_addr;
    tok_t           wr_tok, rd_tok;
    logic           ev_start, ev_fin, ev_err;
    logic [15:0]    ev_tbl;
    logic           accept, expr_open;
    logic [15:0]    table_r;
    logic           syn_r, cap_r;

    bexpr_convert #(.PF_DEPTH(PF_DEPTH), .OS_DEPTH(OS_DEPTH)) u_conv (
        .clk(clk), .rst_n(rst_n), .en(cv_en),
        .in_valid(in_valid), .in_char(in_char), .in_last(in_last), .in_ready(in_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_tok(wr_tok),
        .fin(cv_fin), .fin_syn(cv_syn), .fin_cap(cv_cap)
    );

    bexpr_pbuf #(.DEPTH(PF_DEPTH)) u_pbuf (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_tok),
        .raddr(rd_addr), .rdata(rd_tok)
    );

    bexpr_eval #(.PF_DEPTH(PF_DEPTH), .ES_DEPTH(ES_DEPTH)) u_eval (
        .clk(clk), .rst_n(rst_n), .start(ev_start),
        .rd_addr(rd_addr), .rd_tok(rd_tok),
        .fin(ev_fin), .tbl(ev_tbl), .err(ev_err)
    );

    assign accept = in_valid && in_ready;

    always_comb begin
        nxt = state;
        unique case (state)
            TP_LOAD: if (cv_fin) nxt = (cv_syn || cv_cap) ? TP_DONE : TP_EVAL;
            TP_EVAL: if (ev_fin) nxt = TP_DONE;
            TP_DONE: nxt = TP_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TP_LOAD;
        else        state <= nxt;
    end

    // Outputs decoded from state
    always_comb begin
        cv_en    = (state == TP_LOAD);
        ev_start = (state == TP_LOAD) && cv_fin && !(cv_syn || cv_cap);
        done     = (state == TP_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            expr_open <= 1'b0;
            table_r   <= '0;
            syn_r     <= 1'b0;
            cap_r     <= 1'b0;
        end else begin
            if (accept && !expr_open) begin
                expr_open <= 1'b1;
                syn_r     <= 1'b0;
                cap_r     <= 1'b0;
            end
            if (state == TP_LOAD && cv_fin) begin
                expr_open <= 1'b0;
                if (cv_syn || cv_cap) begin
                    syn_r   <= cv_syn;
                    cap_r   <= cv_cap;
                    table_r <= '0;
                end
            end
            if (state == TP_EVAL && ev_fin) begin
                table_r <= ev_err ? 16'h0000 : ev_tbl;
                cap_r   <= ev_err;
            end
        end
    end

    assign table_out    = table_r;
    assign err_syntax   = syn_r;
    assign err_capacity = cap_r;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (err_syntax || err_capacity)) |-> (table_out == 16'h0000));
    // R10
    ready_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_last) |=> !in_ready);

endmodule

// File: tb/bexpr_tt_engine_test.sv
module bexpr_tt_engine_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [7:0]  in_char;
    logic        in_last;
    logic        in_ready;
    logic [15:0] table_out;
    logic        done;
    logic        err_syntax;
    logic        err_capacity;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    bexpr_tt_engine uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char),
        .in_last(in_last), .in_ready(in_ready), .table_out(table_out),
        .done(done), .err_syntax(err_syntax), .err_capacity(err_capacity)
    );

    function automatic logic [15:0] vmask(input int k);
        logic [15:0] m;
        for (int i = 0; i < 16; i++) m[i] = 1'((i >> k) & 1);
        return m;
    endfunction

    function automatic logic [15:0] apply_op(input byte op, input logic [15:0] a, input logic [15:0] b);
        case (op)
            "+":     return a | b;
            "*":     return a & b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Sends characters; when close is set the final one carries in_last.
    task automatic send_chars(input string s, input bit close);
        for (int k = 0; k < s.len(); k++) begin
            in_valid = 1'b1;
            in_char  = s[k];
            in_last  = close && (k == s.len() - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic finish_case(input string s, input logic [15:0] exp_tbl,
                               input bit exp_syn, input bit exp_cap, input string req);
        check(in_ready == 1'b0, "R10", {"ready low after end ", s}, 16'(in_ready), 16'h0);
        while (!done) @(negedge clk);
        check(table_out == exp_tbl, req, {"table ", s}, table_out, exp_tbl);
        check(err_syntax == exp_syn, req, {"syntax flag ", s}, 16'(err_syntax), 16'(exp_syn));
        check(err_capacity == exp_cap, req, {"capacity flag ", s}, 16'(err_capacity), 16'(exp_cap));
        @(negedge clk);
        check(done == 1'b0, "R10", {"done width ", s}, 16'(done), 16'h0);
    endtask

    task automatic run_case(input string s, input logic [15:0] exp_tbl,
                            input bit exp_syn, input bit exp_cap, input string req);
        send_chars(s, 1'b1);
        finish_case(s, exp_tbl, exp_syn, exp_cap, req);
    endtask

    task automatic report_and_end();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL R10 watchdog expired: actual=running expected=finished");
        report_and_end();
    end

    initial begin
        string s;
        string ops;
        logic [15:0] e;
        ops      = "+*@";
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_char  = 8'h00;
        in_last  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1", "ready", 16'(in_ready), 16'h1);
        check(done == 1'b0, "R1", "done", 16'(done), 16'h0);
        check(table_out == 16'h0, "R1", "table", table_out, 16'h0);
        check(err_syntax == 1'b0 && err_capacity == 1'b0, "R1", "flags",
              {14'h0, err_syntax, err_capacity}, 16'h0);

        // R2 single variables, with skipped letters and spaces
        for (int k = 0; k < 4; k++) run_case($sformatf("I%0d", k), vmask(k), 0, 0, "R2");
        run_case("( I1 + I3 )", vmask(1) | vmask(3), 0, 0, "R2");
        run_case("(0*2)", vmask(0) & vmask(2), 0, 0, "R2");

        // R3 every binary operator on every variable pair
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int o = 0; o < 3; o++)
                    run_case($sformatf("(I%0d%cI%0d)", a, ops[o], b),
                             apply_op(ops[o], vmask(a), vmask(b)), 0, 0, "R3");
        // R3 rank ordering and left grouping
        run_case("(I0+I1*I2)", vmask(0) | (vmask(1) & vmask(2)), 0, 0, "R3");
        run_case("(I0*I1+I2)", (vmask(0) & vmask(1)) | vmask(2), 0, 0, "R3");
        run_case("(I0@I1*I2)", (vmask(0) ^ vmask(1)) & vmask(2), 0, 0, "R3");
        run_case("(I0*I1@I2)", (vmask(0) & vmask(1)) ^ vmask(2), 0, 0, "R3");

        // R4 NOT on either operand
        run_case("(~I0)", ~vmask(0), 0, 0, "R4");
        for (int a = 0; a < 4; a++)
            for (int o = 0; o < 3; o++) begin
                run_case($sformatf("(I%0d%c~I%0d)", a, ops[o], 3 - a),
                         apply_op(ops[o], vmask(a), ~vmask(3 - a)), 0, 0, "R4");
                run_case($sformatf("(~I%0d%cI%0d)", a, ops[o], (a + 1) % 4),
                         apply_op(ops[o], ~vmask(a), vmask((a + 1) % 4)), 0, 0, "R4");
            end

        // R5 nested groups, R11 through multi-pop closings
        run_case("((I0*I1)@(I2*~I3))",
                 (vmask(0) & vmask(1)) ^ (vmask(2) & ~vmask(3)), 0, 0, "R5");
        run_case("(((I3+I2)*I1)@I0)",
                 ((vmask(3) | vmask(2)) & vmask(1)) ^ vmask(0), 0, 0, "R11");
        run_case(")", 16'h0, 1, 0, "R5");

        // R6 unknown characters
        run_case("(I0#I1)", 16'h0, 1, 0, "R6");
        run_case("(I4)", 16'h0, 1, 0, "R6");
        // R9 flags hold after done until next expression starts
        repeat (3) @(negedge clk);
        check(err_syntax == 1'b1, "R9", "flag held", 16'(err_syntax), 16'h1);
        in_valid = 1'b1;
        in_char  = "(";
        in_last  = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check(err_syntax == 1'b0, "R9", "flag cleared on first char", 16'(err_syntax), 16'h0);
        send_chars("I1)", 1'b1);
        finish_case("(I1)", vmask(1), 0, 0, "R9");

        // R7 leftovers at end
        run_case("I0+I1", 16'h0, 1, 0, "R7");
        run_case("(I0+I1", 16'h0, 1, 0, "R7");

        // R8 operator stack: 16 deep fits, 17 overflows
        s = "";
        for (int k = 0; k < 16; k++) s = {s, "("};
        s = {s, "I2"};
        for (int k = 0; k < 16; k++) s = {s, ")"};
        run_case(s, vmask(2), 0, 0, "R8");
        s = {"(", s, ")"};
        run_case(s, 16'h0, 1, 1, "R8");

        // R8 postfix buffer: 32 variables fill 64 slots exactly, 33 overflow
        s = "(I0";
        for (int k = 1; k < 32; k++) s = {s, $sformatf("+I%0d", k % 4)};
        e = vmask(0) | vmask(1) | vmask(2) | vmask(3);
        run_case({s, ")"}, e, 0, 0, "R8");
        run_case({s, "+I0)"}, 16'h0, 0, 1, "R8");

        // R8 evaluation underflow
        run_case("(I0+)", 16'h0, 0, 1, "R8");
        // R9 recovery after an error
        run_case("(I3@I2)", vmask(3) ^ vmask(2), 0, 0, "R9");

        report_and_end();
    end

endmodule